// File: doc/BRIEF.md
# Per-Load Stride Prefetcher

This block watches the stream of load instructions and learns, for each load site, whether it walks memory with a fixed step. A small direct-mapped table is selected by the low bits of the load's program counter. Each entry keeps the upper program-counter bits as a tag, the address the load touched last time, the step it last saw, and one of four confidence states. Every load compares its address with the last address plus the stored step. That result moves the entry's confidence state, and the state can replace the step with the step just seen.

When an entry is in its confident state after the update, the block asks for a prefetch of the current address plus the step. The request appears for one cycle, one clock after the load. It goes to a memory system and buffer that lie outside this block. Address arithmetic is modulo 2^ADDR_W, so a step can be negative.

Top module: `stride_prefetch`

## Requirements
- R1: After reset `pf_valid` is 0 and every table entry is empty, so the first load of any program counter is handled as a miss.
- R2: A load whose entry is empty or holds a different tag (tag = `ld_pc[PC_W-1:IDX_W]`, index = `ld_pc[IDX_W-1:0]`) claims the entry in the INIT state, with step 0 and last address set to the load address, and raises no prefetch.
- R3: A load that hits an INIT entry goes to STEADY if its address equals last address plus step. Otherwise it goes to TRANSIENT, and the step becomes load address minus last address.
- R4: A load that hits a TRANSIENT entry goes to STEADY if the prediction is correct. Otherwise it goes to NO-PREDICTION, and the step becomes the newly observed step.
- R5: A load that hits a STEADY entry stays in STEADY if the prediction is correct. Otherwise it returns to INIT and the step is left unchanged.
- R6: A load that hits a NO-PREDICTION entry moves to TRANSIENT if the prediction is correct. Otherwise it stays in NO-PREDICTION, and the step becomes the newly observed step.
- R7: The last-address field is set to the load address on every load that touches the entry. `pf_valid` is 1 in the cycle after a load exactly when that entry's updated state is STEADY, and `pf_addr` then equals load address plus step, modulo 2^ADDR_W.
- R8: In a cycle without `ld_valid`, the table is unchanged and the next cycle shows `pf_valid` = 0, whatever `ld_pc` and `ld_addr` carry.
- R9: Loads whose program counters differ in index keep separate entries. A load with the same index and a different tag replaces the older entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Address of the load |
| pf_valid | output | 1 | Prefetch request, one cycle after the load |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The NO-PREDICTION state is the hardest to reach from the ports. Getting there takes one load site that first settles on one step, then breaks it twice in a row with two different steps. Getting back out then takes two correct predictions before any prefetch appears. The vector table drives one program counter through exactly that path, including a negative step. It then checks that a later prefetch uses the step kept across a STEADY-to-INIT miss. Directed tests cover an index-aliasing eviction, idle cycles carrying junk inputs, and a reset that erases a confident entry.

// File: rtl/stride_prefetch.sv
module stride_prefetch #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;

  typedef enum logic [1:0] {ST_INIT, ST_TRANS, ST_STEADY, ST_NOPRED} conf_t;

  logic              ent_vld    [ENTRIES];
  logic [TAG_W-1:0]  ent_tag    [ENTRIES];
  logic [ADDR_W-1:0] ent_prev   [ENTRIES];
  logic [ADDR_W-1:0] ent_stride [ENTRIES];
  conf_t             ent_st     [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, correct, upd;
  conf_t             cur_st, nxt_st;
  logic [ADDR_W-1:0] cur_prev, cur_stride, obs_stride, nxt_stride;

  assign idx        = ld_pc[IDX_W-1:0];
  assign tag        = ld_pc[PC_W-1:IDX_W];
  assign hit        = ent_vld[idx] && (ent_tag[idx] == tag);
  assign cur_st     = ent_st[idx];
  assign cur_prev   = ent_prev[idx];
  assign cur_stride = ent_stride[idx];
  assign correct    = (ld_addr == cur_prev + cur_stride);
  assign obs_stride = ld_addr - cur_prev;

  always_comb begin
    nxt_st = cur_st;
    upd    = 1'b0;
    if (!hit) begin
      nxt_st = ST_INIT;
    end else begin
      unique case (cur_st)
        ST_INIT:   begin nxt_st = correct ? ST_STEADY : ST_TRANS;  upd = !correct; end
        ST_TRANS:  begin nxt_st = correct ? ST_STEADY : ST_NOPRED; upd = !correct; end
        ST_STEADY: begin nxt_st = correct ? ST_STEADY : ST_INIT;   upd = 1'b0;     end
        ST_NOPRED: begin nxt_st = correct ? ST_TRANS  : ST_NOPRED; upd = !correct; end
      endcase
    end
  end

  assign nxt_stride = !hit ? '0 : (upd ? obs_stride : cur_stride);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_vld[i] <= 1'b0;
    end else if (ld_valid) begin
      ent_vld[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid) begin
      ent_tag[idx]    <= tag;
      ent_prev[idx]   <= ld_addr;
      ent_stride[idx] <= nxt_stride;
      ent_st[idx]     <= nxt_st;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= ld_valid && hit && (nxt_st == ST_STEADY);
      if (ld_valid) pf_addr <= ld_addr + nxt_stride;
    end
  end
endmodule

module stride_prefetch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              hit,
  input logic              correct,
  input logic [1:0]        cur_st,
  input logic [ADDR_W-1:0] cur_stride,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pf_valid);

  a_r2_miss_no_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !hit) |=> !pf_valid);

  a_r8_idle_no_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !pf_valid);

  a_r5_steady_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && hit && cur_st == 2'd2 && correct) |=>
      (pf_valid && pf_addr == $past(ld_addr) + $past(cur_stride)));

  a_r5_steady_break: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && hit && cur_st == 2'd2 && !correct) |=> !pf_valid);

  a_r3_init_wrong: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && hit && cur_st == 2'd0 && !correct) |=> !pf_valid);

  a_r6_nopred_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && hit && cur_st == 2'd3) |=> !pf_valid);
endmodule

bind stride_prefetch stride_prefetch_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
  .hit(hit), .correct(correct), .cur_st(cur_st), .cur_stride(cur_stride),
  .pf_valid(pf_valid), .pf_addr(pf_addr)
);

// File: tb/test_stride_prefetch.sv
module test_stride_prefetch;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_pc = '0;
  logic [31:0] ld_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int total = 0;
  int bad = 0;

  stride_prefetch i_stride_prefetch (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
    .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {pc, addr, expected pf_valid, expected pf_addr}
  localparam logic [96:0] VEC [NV] = '{
    {32'h100, 32'h1000, 1'b0, 32'h0},        // R2 miss allocates
    {32'h100, 32'h1010, 1'b0, 32'h0},        // R3 init wrong -> trans
    {32'h100, 32'h1020, 1'b1, 32'h1030},     // R4 trans right -> steady
    {32'h100, 32'h1030, 1'b1, 32'h1040},     // R5 steady right
    {32'h100, 32'h1050, 1'b0, 32'h0},        // R5 steady wrong -> init
    {32'h100, 32'h1060, 1'b1, 32'h1070},     // R5 step kept
    {32'h100, 32'h1000, 1'b0, 32'h0},        // R5 -> init
    {32'h100, 32'h1008, 1'b0, 32'h0},        // R3 init wrong, step 8
    {32'h100, 32'h1000, 1'b0, 32'h0},        // R4 trans wrong -> nopred
    {32'h100, 32'h1004, 1'b0, 32'h0},        // R6 nopred wrong, step 4
    {32'h100, 32'h1008, 1'b0, 32'h0},        // R6 nopred right -> trans
    {32'h100, 32'h100C, 1'b1, 32'h1010},     // R4 trans right -> steady
    {32'h100, 32'h1008, 1'b0, 32'h0},        // R5 -> init
    {32'h100, 32'h1004, 1'b0, 32'h0},        // R3 step -4
    {32'h100, 32'h1000, 1'b1, 32'h0FFC},     // R7 negative step
    {32'h204, 32'h5000, 1'b0, 32'h0},        // R9 second entry
    {32'h204, 32'h5100, 1'b0, 32'h0},
    {32'h204, 32'h5200, 1'b1, 32'h5300},
    {32'h100, 32'h0FFC, 1'b1, 32'h0FF8}      // R9 first entry intact
  };

  function automatic string req_of(int k);
    case (k)
      0: return "R2";
      1, 7, 13: return "R3";
      2, 8, 11: return "R4";
      3, 4, 5, 6, 12: return "R5";
      9, 10: return "R6";
      14: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic exp_v, logic [31:0] exp_a);
    total++;
    if (pf_valid !== exp_v || (exp_v && pf_addr !== exp_a)) begin
      bad++;
      $display("FAIL %s: got v=%0b a=%h, expected v=%0b a=%h",
               req, pf_valid, pf_addr, exp_v, exp_a);
    end
  endtask

  task automatic do_load(logic [31:0] pc, logic [31:0] a);
    @(negedge clk);
    ld_valid = 1'b1; ld_pc = pc; ld_addr = a;
    @(posedge clk); #1;
    ld_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 1'b0, '0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      do_load(VEC[k][96:65], VEC[k][64:33]);
      check(req_of(k), VEC[k][32], VEC[k][31:0]);
    end

    // R9 aliasing: same index as 0x100, different tag, evicts it
    do_load(32'h300, 32'h2000);
    check("R9", 1'b0, '0);
    do_load(32'h100, 32'h0FF8);
    check("R9", 1'b0, '0);
    do_load(32'h100, 32'h0FF8);   // step 0 from fresh entry -> steady
    check("R2", 1'b1, 32'h0FF8);

    // R8 idle cycles with junk inputs leave table and output quiet
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ld_valid = 1'b0; ld_pc = 32'h100; ld_addr = 32'hDEAD0000 + k;
      @(posedge clk); #1;
      check("R8", 1'b0, '0);
    end
    do_load(32'h100, 32'h0FF8);
    check("R8", 1'b1, 32'h0FF8);

    // R7 pulse lasts one cycle
    @(posedge clk); #1;
    check("R7", 1'b0, '0);

    // R1 reset forgets a confident entry
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1", 1'b0, '0);
    @(negedge clk); rst_n = 1'b1;
    do_load(32'h204, 32'h5300);
    check("R1", 1'b0, '0);
    do_load(32'h204, 32'h5300);
    check("R1", 1'b1, 32'h5300);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule